// File: doc/BRIEF.md
# Smart Card Status Word with Guard-Time Monitor

This block assembles the read-only status byte of a smart card reader interface. It gathers live conditions from the surrounding logic and presents them as one 8-bit word. Those conditions are the receive FIFO occupancy, the two card presence contacts, an auxiliary interrupt pin, a transmit/receive ready flag, a control-ready flag and the clock-switch completion events. Software reads the word through a small address-decoded read port, and a read never changes any state.

The block also holds the guard-time timer that watches the card I/O line. Every detected start bit, in either direction, zeroes a counter of ETU ticks. When the count reaches the protocol's limit before the next start bit, the guard-time bit rises. The limit is 16 ETU for protocol T=0 and 22 ETU for T=1. The counter saturates at the limit. A change of protocol takes effect at once.

None of the fields drives an interrupt. The UART datapath, the FIFO storage and the clock generation sit outside this block.

Top module: `sc_status_mon`

## Requirements
- R1: The word is laid out as bit 7 clock-switch done, bit 6 FIFO empty, bit 5 guard time elapsed, bit 4 control ready, bit 3 card 2 present, bit 2 card 1 present, bit 1 auxiliary pin, bit 0 transmit/receive ready.
- R2: While reset is held, and just after it, the word reads 0x50 whatever the inputs are: FIFO empty and control ready are 1, every other bit is 0.
- R3: After a start bit, the guard bit becomes 1 on the clock edge that counts the limit-th ETU tick. The limit is 16 when `proto_t1`=0 and 22 when `proto_t1`=1. The bit stays 0 for fewer ticks, and it stays 0 whatever the tick count if no start bit has been seen since reset.
- R4: A start-bit pulse clears the guard bit and zeroes the count on the same edge. A tick in the same cycle as a start bit is not counted.
- R5: Once the limit is reached, the count saturates and the guard bit holds 1 until the next start bit, whatever further ticks arrive.
- R6: A protocol change while counting applies the new limit on the next edge. If the current count already meets the new limit, the guard bit sets on that edge.
- R7: The FIFO-empty bit equals (`fifo_count` == 0), registered with one cycle of latency.
- R8: A switch-to-fast event alone sets the clock-switch bit. A switch-to-slow event alone clears it. If both events arrive together, or neither does, the bit holds.
- R9: Card presence and auxiliary pin inputs pass through a two-flop synchronizer. A change shows in the word after the second clock edge and not after the first.
- R10: The control-ready and transmit/receive-ready bits follow their inputs with one cycle of latency.
- R11: `rd_data` shows the word combinationally when `rd_en`=1 and `rd_addr` equals `STATUS_ADDR` (default 0xC), and shows 0 otherwise. Reading changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| etu_tick | input | 1 | One-cycle strobe per elapsed ETU |
| start_bit | input | 1 | One-cycle pulse on each start bit seen on the I/O line |
| proto_t1 | input | 1 | 1 selects protocol T=1, 0 selects T=0 |
| fifo_count | input | FIFO_CNT_W | Characters held in the receive FIFO |
| clksw_to_fast | input | 1 | Event: switch to half internal clock completed |
| clksw_to_slow | input | 1 | Event: switch back to divided crystal clock completed |
| card1_present | input | 1 | Card 1 presence contact (asynchronous) |
| card2_present | input | 1 | Card 2 presence contact (asynchronous) |
| aux_pin | input | 1 | Auxiliary interrupt pin level (asynchronous) |
| txrx_ready | input | 1 | Transmit-empty / receive-full flag |
| ctrl_ready | input | 1 | Control-ready flag |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Status word, or 0 when not selected |

## Verification
Two events can fall in the same cycle and compete for the guard-time bit: a start bit and the ETU tick that would complete the guard interval or extend the count. The bench provokes this by first running a count to the limit. It then pulses the start bit and a tick together, and counts again one tick short of the limit and then to it. The result is judged against the rule that the start bit wins, so the guard bit must read 0 until exactly the limit number of further ticks. A second collision is the two clock-switch events arriving together, which must leave the bit unchanged.

// File: rtl/sc_stat_pkg.sv
// Package: shared status-word layout for the smart card status monitor.
// Assumes: the bit order below is what software decodes; do not reorder.
package sc_stat_pkg;

    // Status word, most significant field first (bit 7 down to bit 0).
    typedef struct packed {
        logic clk_fast;    // bit 7: clock-switch to fast clock completed
        logic fifo_empty;  // bit 6: receive FIFO holds no characters
        logic guard_done;  // bit 5: guard interval elapsed since last start bit
        logic ctrl_rdy;    // bit 4: control ready
        logic card2;       // bit 3: card 2 present
        logic card1;       // bit 2: card 1 present
        logic aux;         // bit 1: auxiliary pin state
        logic txrx_rdy;    // bit 0: transmit empty / receive full
    } status_word_t;

    localparam int STATUS_W = $bits(status_word_t);

    // Reset image of the word: FIFO empty and control ready set.
    localparam status_word_t STATUS_RESET = '{
        clk_fast:   1'b0,
        fifo_empty: 1'b1,
        guard_done: 1'b0,
        ctrl_rdy:   1'b1,
        card2:      1'b0,
        card1:      1'b0,
        aux:        1'b0,
        txrx_rdy:   1'b0
    };

    // Larger of two guard limits, used to size the counter.
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sc_sync2.sv
// Module: sc_sync2
// Two-flop synchronizer for a bundle of independent asynchronous levels.
// Assumes: each bit is a slow level; no bus coherency across bits is needed.
module sc_sync2 #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic meta_q;
            logic stab_q;

            // Two-stage capture of one asynchronous bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= async_in[i];
                    stab_q <= meta_q;
                end
            end

            assign sync_out[i] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/sc_guard_timer.sv
// Module: sc_guard_timer
// Counts ETU ticks from the latest start bit and flags when the
// protocol-dependent guard limit is reached before the next start bit.
// Assumes: etu_tick and start_bit are single-cycle pulses in the clk domain;
// proto_t1 is a level that software may change at any time.
module sc_guard_timer #(
    parameter int LIMIT_T0 = 16,
    parameter int LIMIT_T1 = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic etu_tick,
    input  logic start_bit,
    input  logic proto_t1,
    output logic guard_done
);

    import sc_stat_pkg::*;

    localparam int LIMIT_MAX = max_of(LIMIT_T0, LIMIT_T1);
    localparam int CNT_W     = $clog2(LIMIT_MAX + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] limit;
    logic             running_q, running_d;
    logic             done_q, done_d;

    // Select the active limit from the current protocol.
    always_comb begin
        limit = proto_t1 ? CNT_W'(LIMIT_T1) : CNT_W'(LIMIT_T0);
    end

    // Next-state: a start bit wins, else count up to a saturating limit.
    always_comb begin
        cnt_d     = cnt_q;
        done_d    = done_q;
        running_d = running_q | start_bit;
        if (start_bit) begin
            cnt_d  = '0;
            done_d = 1'b0;
        end else if (running_q) begin
            if (etu_tick && (cnt_q < limit)) begin
                cnt_d = cnt_q + 1'b1;
            end
            if (cnt_d >= limit) begin
                done_d = 1'b1;
            end
        end
    end

    // State registers of the guard timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            done_q    <= 1'b0;
            running_q <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            done_q    <= done_d;
            running_q <= running_d;
        end
    end

    assign guard_done = done_q;

    // R4: a start bit leaves the flag and the count cleared.
    assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_bit |=> (!done_q && (cnt_q == '0)));

    // R3: the flag only rises once the count has reached the limit in force.
    assert_rise_at_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> (cnt_q >= $past(limit)));

    // R3: no flag before the first start bit after reset.
    assert_idle_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !running_q |-> !done_q);

    // R5: at or above the limit the count stays put.
    assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !start_bit && (cnt_q >= limit)) |=> $stable(cnt_q));

    // R5: the flag stays set until a start bit.
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !start_bit) |=> done_q);

endmodule

// File: rtl/sc_clksw_track.sv
// Module: sc_clksw_track
// Remembers which clock-switch direction completed last.
// Assumes: completion events are single-cycle pulses; coincident events
// carry no usable direction and are ignored.
module sc_clksw_track (
    input  logic clk,
    input  logic rst_n,
    input  logic to_fast,
    input  logic to_slow,
    output logic on_fast
);

    logic fast_q;

    // Set on a lone fast event, clear on a lone slow event, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
        end else if (to_fast && !to_slow) begin
            fast_q <= 1'b1;
        end else if (to_slow && !to_fast) begin
            fast_q <= 1'b0;
        end
    end

    assign on_fast = fast_q;

    // R8: a lone fast event sets the bit.
    assert_fast_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (to_fast && !to_slow) |=> fast_q);

    // R8: a lone slow event clears the bit.
    assert_slow_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (to_slow && !to_fast) |=> !fast_q);

    // R8: with both or neither event the bit holds.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (to_fast == to_slow) |=> $stable(fast_q));

endmodule

// File: rtl/sc_status_mon.sv
// Module: sc_status_mon
// Read-only status word of a smart card reader interface. It registers the
// live flags, synchronizes the pin inputs, tracks the clock switch and runs
// the guard-time timer, then exposes the word through an address-decoded
// read port with no side effects.
// Assumes: card presence and aux inputs are asynchronous levels; all other
// inputs are synchronous to clk. No field feeds any interrupt.
module sc_status_mon #(
    parameter int              FIFO_CNT_W  = 4,
    parameter int              ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'hC,
    parameter int              LIMIT_T0    = 16,
    parameter int              LIMIT_T1    = 22
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  etu_tick,
    input  logic                  start_bit,
    input  logic                  proto_t1,
    input  logic [FIFO_CNT_W-1:0] fifo_count,
    input  logic                  clksw_to_fast,
    input  logic                  clksw_to_slow,
    input  logic                  card1_present,
    input  logic                  card2_present,
    input  logic                  aux_pin,
    input  logic                  txrx_ready,
    input  logic                  ctrl_ready,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [7:0]            rd_data
);

    import sc_stat_pkg::*;

    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pins_async, pins_sync;
    logic             guard_done;
    logic             on_fast;
    logic             fe_q, cred_q, trdy_q;
    logic             rd_hit;
    status_word_t     word;

    assign pins_async = {card2_present, card1_present, aux_pin};

    sc_sync2 #(.W(PIN_W)) u_pin_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_async),
        .sync_out (pins_sync)
    );

    sc_guard_timer #(.LIMIT_T0(LIMIT_T0), .LIMIT_T1(LIMIT_T1)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .etu_tick   (etu_tick),
        .start_bit  (start_bit),
        .proto_t1   (proto_t1),
        .guard_done (guard_done)
    );

    sc_clksw_track u_clksw (
        .clk     (clk),
        .rst_n   (rst_n),
        .to_fast (clksw_to_fast),
        .to_slow (clksw_to_slow),
        .on_fast (on_fast)
    );

    // Register the synchronous live flags with their own reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fe_q   <= STATUS_RESET.fifo_empty;
            cred_q <= STATUS_RESET.ctrl_rdy;
            trdy_q <= STATUS_RESET.txrx_rdy;
        end else begin
            fe_q   <= (fifo_count == '0);
            cred_q <= ctrl_ready;
            trdy_q <= txrx_ready;
        end
    end

    // Assemble the status word in its fixed field order.
    always_comb begin
        word.clk_fast   = on_fast;
        word.fifo_empty = fe_q;
        word.guard_done = guard_done;
        word.ctrl_rdy   = cred_q;
        word.card2      = pins_sync[2];
        word.card1      = pins_sync[1];
        word.aux        = pins_sync[0];
        word.txrx_rdy   = trdy_q;
    end

    // Address-decoded read mux; pure combinational, no state touched.
    always_comb begin
        rd_hit  = rd_en && (rd_addr == STATUS_ADDR);
        rd_data = rd_hit ? word : '0;
    end

    // R7: a non-empty FIFO clears the empty bit on the next edge.
    assert_fifo_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count != '0) |=> !word.fifo_empty);

    // R7: an empty FIFO sets the empty bit on the next edge.
    assert_fifo_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == '0) |=> word.fifo_empty);

    // R10: control ready follows its input one cycle later.
    assert_cred_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (word.ctrl_rdy == $past(ctrl_ready)));

    // R11: an unselected read presents zero.
    assert_read_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == 8'h00));

endmodule

// File: tb/sc_status_mon_bench.sv
`timescale 1ns/1ps
module sc_status_mon_bench;

    localparam int FW  = 4;
    localparam int AW  = 4;
    localparam int LT0 = 16;
    localparam int LT1 = 22;
    localparam logic [AW-1:0] SADDR = 4'hC;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          etu_tick, start_bit, proto_t1;
    logic [FW-1:0] fifo_count;
    logic          clksw_to_fast, clksw_to_slow;
    logic          card1_present, card2_present, aux_pin;
    logic          txrx_ready, ctrl_ready;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    sc_status_mon #(
        .FIFO_CNT_W(FW), .ADDR_W(AW), .STATUS_ADDR(SADDR),
        .LIMIT_T0(LT0), .LIMIT_T1(LT1)
    ) u_sc_status_mon (
        .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .start_bit(start_bit),
        .proto_t1(proto_t1), .fifo_count(fifo_count),
        .clksw_to_fast(clksw_to_fast), .clksw_to_slow(clksw_to_slow),
        .card1_present(card1_present), .card2_present(card2_present),
        .aux_pin(aux_pin), .txrx_ready(txrx_ready), .ctrl_ready(ctrl_ready),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Read the status word mid-cycle through the read port.
    task automatic read_word(output logic [7:0] w);
        rd_en = 1'b1; rd_addr = SADDR;
        #0.5;
        w = rd_data;
        rd_en = 1'b0;
        #0.1;
    endtask

    task automatic ticks(input int n);
        etu_tick = 1'b1;
        step(n);
        etu_tick = 1'b0;
    endtask

    task automatic pulse_start();
        start_bit = 1'b1;
        step(1);
        start_bit = 1'b0;
    endtask

    // Guard bit sits at bit 5.
    function automatic logic [7:0] gbit(input logic [7:0] w);
        return {7'b0, w[5]};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] w, w2;
        logic [7:0] exp;
        int lim;

        rst_n = 1'b0;
        etu_tick = 0; start_bit = 0; proto_t1 = 0;
        fifo_count = 4'd5; clksw_to_fast = 0; clksw_to_slow = 0;
        card1_present = 1; card2_present = 1; aux_pin = 1;
        txrx_ready = 1; ctrl_ready = 0;
        rd_en = 0; rd_addr = '0;
        step(3);
        // R2: reset image irrespective of inputs
        read_word(w);
        check("R2 reset word", w, 8'h50);

        // Return inputs to quiet values and release reset
        fifo_count = 0; card1_present = 0; card2_present = 0; aux_pin = 0;
        txrx_ready = 0; ctrl_ready = 1;
        rst_n = 1'b1;
        step(1);
        read_word(w);
        check("R2 word after release", w, 8'h50);

        // R11: wrong address and no strobe read zero
        rd_en = 1'b1; rd_addr = 4'h3; #0.5;
        check("R11 wrong address", rd_data, 8'h00);
        rd_en = 1'b0; rd_addr = SADDR; #0.5;
        check("R11 no strobe", rd_data, 8'h00);
        step(1);

        // R3: ticks before any start bit never set the guard bit
        ticks(30);
        read_word(w);
        check("R3 no start seen", gbit(w), 8'h0);

        // R3: sweep tick counts for both protocols
        for (int p = 0; p < 2; p++) begin
            proto_t1 = p[0];
            lim = p ? LT1 : LT0;
            for (int n = 0; n <= lim + 2; n++) begin
                pulse_start();
                read_word(w);
                check("R4 cleared by start", gbit(w), 8'h0);
                if (n > 0) ticks(n);
                read_word(w);
                exp = (n >= lim) ? 8'h1 : 8'h0;
                check(p ? "R3 T1 sweep" : "R3 T0 sweep", gbit(w), exp);
            end
        end

        // R4: start and tick together; the tick is not counted
        proto_t1 = 0;
        pulse_start();
        ticks(LT0);
        start_bit = 1'b1; etu_tick = 1'b1;
        step(1);
        start_bit = 1'b0; etu_tick = 1'b0;
        read_word(w);
        check("R4 collision clears", gbit(w), 8'h0);
        ticks(LT0 - 1);
        read_word(w);
        check("R4 tick with start not counted", gbit(w), 8'h0);
        ticks(1);
        read_word(w);
        check("R4 limit after collision", gbit(w), 8'h1);

        // R5: many extra ticks and a protocol change keep the bit set
        ticks(40);
        read_word(w);
        check("R5 saturated", gbit(w), 8'h1);
        proto_t1 = 1;
        step(2);
        read_word(w);
        check("R5 sticky across protocol", gbit(w), 8'h1);

        // R6: counting in T1, switch to T0 once the count passes 16
        proto_t1 = 1;
        pulse_start();
        ticks(18);
        read_word(w);
        check("R6 below T1 limit", gbit(w), 8'h0);
        proto_t1 = 0;
        step(1);
        read_word(w);
        check("R6 new limit applied", gbit(w), 8'h1);
        // R6: T0 to T1 below the new limit keeps counting
        proto_t1 = 0;
        pulse_start();
        ticks(10);
        proto_t1 = 1;
        ticks(LT1 - 10 - 1);
        read_word(w);
        check("R6 raised limit not met", gbit(w), 8'h0);
        ticks(1);
        read_word(w);
        check("R6 raised limit met", gbit(w), 8'h1);

        // R11: reads have no side effects on the word or the timer
        pulse_start();
        ticks(5);
        read_word(w);
        read_word(w2);
        check("R11 repeated read stable", w2, w);
        ticks(LT1 - 5);
        read_word(w);
        check("R11 count unaffected by reads", gbit(w), 8'h1);

        // R7: fifo-empty bit over every count value
        for (int c = 0; c < (1 << FW); c++) begin
            fifo_count = FW'(c);
            step(1);
            read_word(w);
            check("R7 fifo empty", {7'b0, w[6]}, (c == 0) ? 8'h1 : 8'h0);
        end
        fifo_count = 0;

        // R8: clock-switch events
        clksw_to_fast = 1; step(1); clksw_to_fast = 0;
        read_word(w);
        check("R8 fast sets", {7'b0, w[7]}, 8'h1);
        clksw_to_fast = 1; clksw_to_slow = 1; step(1);
        clksw_to_fast = 0; clksw_to_slow = 0;
        read_word(w);
        check("R8 both hold set", {7'b0, w[7]}, 8'h1);
        clksw_to_slow = 1; step(1); clksw_to_slow = 0;
        read_word(w);
        check("R8 slow clears", {7'b0, w[7]}, 8'h0);
        clksw_to_fast = 1; clksw_to_slow = 1; step(1);
        clksw_to_fast = 0; clksw_to_slow = 0;
        read_word(w);
        check("R8 both hold clear", {7'b0, w[7]}, 8'h0);

        // R9 and R1: every pin combination, two-edge latency, field positions
        for (int v = 1; v < 8; v++) begin
            card2_present = v[2]; card1_present = v[1]; aux_pin = v[0];
            step(1);
            read_word(w);
            check("R9 not after one edge", {5'b0, w[3:1]}, 8'h0);
            step(1);
            read_word(w);
            check("R1 R9 pin fields", {5'b0, w[3:1]}, {5'b0, v[2:0]});
            card2_present = 0; card1_present = 0; aux_pin = 0;
            step(2);
        end

        // R10: ready flags follow with one cycle
        txrx_ready = 1; ctrl_ready = 0;
        step(1);
        read_word(w);
        check("R10 flags", {6'b0, w[4], w[0]}, 8'h01);
        txrx_ready = 0; ctrl_ready = 1;
        step(1);
        read_word(w);
        check("R10 flags back", {6'b0, w[4], w[0]}, 8'h02);

        // R1: a full word with every field set
        proto_t1 = 0;
        pulse_start();
        ticks(LT0);
        clksw_to_fast = 1; txrx_ready = 1; ctrl_ready = 1;
        card1_present = 1; card2_present = 1; aux_pin = 1; fifo_count = 0;
        step(1);
        clksw_to_fast = 0;
        step(2);
        read_word(w);
        check("R1 all fields set", w, 8'hFF);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule